// File: doc/BRIEF.md
# Serial Control Register Slave for a Stereo Tone and Volume Processor

This block is a write-only I2C target that keeps the control settings of a stereo audio path: source selection, input gain, volume, bass, treble and a separate attenuator for each speaker side. A fast system clock samples SCL and SDA. Both lines are synchronized and filtered before the block looks for START and STOP conditions. It matches one fixed device address and acknowledges every byte it accepts by pulling SDA low. The byte after the address picks a function slot. Every later byte is stored into that slot, or into a run of slots when auto-increment is asked for.

Each slot appears on its own output bus, trimmed to the width the function needs. A one-cycle strobe with the slot index marks every store. Downstream logic can use it to retime a gain change. After reset the settings give a silent but sensible state: the source is set and the volume and both attenuators are in mute.

Top module: `audio_ctl_i2c_slave`

## Requirements
- R1: After reset the outputs are: source select 2'b10, input gain 4'b1110, volume 6'b111111, bass 4'b0111, treble 4'b1110, right and left speaker 7'b1111111. The SDA drive is released and the strobe is low.
- R2: Only the address byte 8'h88 (7-bit address 7'b1000100 with the write bit 0) is acknowledged. Any other address byte, including 8'h89, gets no acknowledge, and every byte after it is ignored until the next START. Bytes clocked without a START are ignored too.
- R3: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. Data bits are taken on SCL rising edges, MSB first, eight to a byte.
- R4: For each accepted byte the SDA drive (sda_oe_o = 1 means pull low) is on across the whole ninth SCL high period. The drive only changes while the filtered SCL is low.
- R5: In the byte after the address, bit 4 is the auto-increment flag and bits 3:0 form a slot index. Bits 7:5 have no effect.
- R6: With the flag at 0, every data byte up to STOP goes to the same slot.
- R7: With the flag at 1, the first data byte goes to the sent index. The index then grows by one per byte as a 4-bit count that wraps from 15 to 0. Slot 4 (no function) is stepped through like any other slot.
- R8: Data bytes aimed at indices 8 to 15 are acknowledged but change no output and give no strobe.
- R9: Each stored data byte gives exactly one wr_stb_o cycle. wr_idx_o (3 bits) holds the slot index, and the slot output shows the new value in that same cycle.
- R10: Slot indices are: 0 source select, 1 gain, 2 volume, 3 bass, 4 none, 5 treble, 6 right speaker, 7 left speaker. Each slot keeps only the low bits of its width (2, 4, 6, 4, 0, 4, 7, 7) and drops the upper data bits.
- R11: A repeated START returns the block to address matching and leaves all slot contents as they were.
- R12: A slot output changes only in a cycle with wr_stb_o high and wr_idx_o equal to that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| src_sel_o | output | 2 | Source select slot |
| in_gain_o | output | 4 | Input gain slot |
| volume_o | output | 6 | Volume slot |
| bass_o | output | 4 | Bass slot |
| treble_o | output | 4 | Treble slot |
| spk_r_o | output | 7 | Right speaker attenuator slot |
| spk_l_o | output | 7 | Left speaker attenuator slot |
| wr_stb_o | output | 1 | One-cycle pulse per stored data byte |
| wr_idx_o | output | 3 | Slot index of the store |

## Verification
On every cycle the assertions check three things: the acknowledge drive never toggles while the filtered SCL is high, the strobe never lasts more than one cycle, and no slot output moves without a strobe naming that slot. The bench scenarios cover what depends on the byte history of a transfer: address rejection, the same-slot and stepping modes, wrap-around past index 15, discarding of indices 8 to 15, masking of upper data bits and recovery after a repeated START. A reference model in the bench computes the expected value of each of these.

// File: rtl/audio_ctl_pkg.sv
package audio_ctl_pkg;
  localparam int NUM_FUNC   = 8;
  localparam int FUNC_IDX_W = $clog2(NUM_FUNC);
  localparam int SUB_IDX_W  = FUNC_IDX_W + 1;
  localparam int DATA_W     = 8;
  localparam int SUB_AUTO_BIT = 4;

  localparam int W_SEL  = 2;
  localparam int W_GAIN = 4;
  localparam int W_VOL  = 6;
  localparam int W_TONE = 4;
  localparam int W_SPK  = 7;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SUB,
    PH_DATA
  } phase_e;

  // bits kept by each function slot
  function automatic int fld_width(input int idx);
    case (idx)
      0:       return W_SEL;
      1:       return W_GAIN;
      2:       return W_VOL;
      3:       return W_TONE;
      5:       return W_TONE;
      6:       return W_SPK;
      7:       return W_SPK;
      default: return 0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] fld_mask(input int idx);
    return DATA_W'((1 << fld_width(idx)) - 1);
  endfunction

  // power-up settings: source 2, gain 28 dB, bass flat, treble +2 dB, mutes
  function automatic logic [DATA_W-1:0] fld_default(input int idx);
    case (idx)
      0:       return 8'h02;
      1:       return 8'h0E;
      2:       return 8'h3F;
      3:       return 8'h07;
      5:       return 8'h0E;
      6:       return 8'h7F;
      7:       return 8'h7F;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    win_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      win_q  <= '1;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      win_q  <= {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&win_q)
        dout <= 1'b1;
      else if (~|win_q)
        dout <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_rx_fsm.sv
module i2c_rx_fsm
  import audio_ctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000100
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl,
  input  logic                  sda,
  output logic                  sda_oe,
  output logic                  wr_en,
  output logic [FUNC_IDX_W-1:0] wr_idx,
  output logic [DATA_W-1:0]     wr_data
);
  localparam logic [DATA_W-1:0] ADDR_BYTE = {DEV_ADDR, 1'b0};
  localparam int CNT_W = $clog2(DATA_W);

  phase_e               phase_q;
  logic                 scl_d, sda_d;
  logic [DATA_W-1:0]    shreg_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 got_q, in_ack_q, auto_q;
  logic [SUB_IDX_W-1:0] idx_q;

  logic start_c, stop_c, rise_c, fall_c;
  assign start_c = scl & scl_d & sda_d & ~sda;
  assign stop_c  = scl & scl_d & ~sda_d & sda;
  assign rise_c  = scl & ~scl_d;
  assign fall_c  = ~scl & scl_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl;
      sda_d <= sda;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      shreg_q  <= '0;
      cnt_q    <= '0;
      got_q    <= 1'b0;
      in_ack_q <= 1'b0;
      auto_q   <= 1'b0;
      idx_q    <= '0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_c || stop_c) begin
        phase_q  <= start_c ? PH_ADDR : PH_IDLE;
        cnt_q    <= '0;
        got_q    <= 1'b0;
        in_ack_q <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (phase_q != PH_IDLE) begin
        if (rise_c && !in_ack_q && !got_q) begin
          shreg_q <= {shreg_q[DATA_W-2:0], sda};
          cnt_q   <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(DATA_W - 1))
            got_q <= 1'b1;
        end else if (fall_c && got_q) begin
          got_q <= 1'b0;
          case (phase_q)
            PH_ADDR: begin
              if (shreg_q == ADDR_BYTE) begin
                phase_q  <= PH_SUB;
                in_ack_q <= 1'b1;
                sda_oe   <= 1'b1;
              end else begin
                phase_q <= PH_IDLE;
              end
            end
            PH_SUB: begin
              auto_q   <= shreg_q[SUB_AUTO_BIT];
              idx_q    <= shreg_q[SUB_IDX_W-1:0];
              phase_q  <= PH_DATA;
              in_ack_q <= 1'b1;
              sda_oe   <= 1'b1;
            end
            default: begin
              in_ack_q <= 1'b1;
              sda_oe   <= 1'b1;
              if (!idx_q[SUB_IDX_W-1]) begin
                wr_en   <= 1'b1;
                wr_idx  <= idx_q[FUNC_IDX_W-1:0];
                wr_data <= shreg_q;
              end
              if (auto_q)
                idx_q <= idx_q + SUB_IDX_W'(1);
            end
          endcase
        end else if (fall_c && in_ack_q) begin
          in_ack_q <= 1'b0;
          sda_oe   <= 1'b0;
          cnt_q    <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/audio_reg_bank.sv
module audio_reg_bank
  import audio_ctl_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [FUNC_IDX_W-1:0]      wr_idx,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [NUM_FUNC*DATA_W-1:0] regs_flat,
  output logic                       stb,
  output logic [FUNC_IDX_W-1:0]      stb_idx
);
  for (genvar g = 0; g < NUM_FUNC; g++) begin : g_slot
    localparam logic [DATA_W-1:0] MSK = fld_mask(g);
    localparam logic [DATA_W-1:0] DEF = fld_default(g) & MSK;
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst)
        slot_q <= DEF;
      else if (wr_en && wr_idx == FUNC_IDX_W'(g))
        slot_q <= wr_data & MSK;
    end
    assign regs_flat[g*DATA_W +: DATA_W] = slot_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb     <= 1'b0;
      stb_idx <= '0;
    end else begin
      stb     <= wr_en;
      stb_idx <= wr_en ? wr_idx : stb_idx;
    end
  end
endmodule

// File: rtl/audio_ctl_i2c_slave.sv
module audio_ctl_i2c_slave
  import audio_ctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1000100,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [W_SEL-1:0]      src_sel_o,
  output logic [W_GAIN-1:0]     in_gain_o,
  output logic [W_VOL-1:0]      volume_o,
  output logic [W_TONE-1:0]     bass_o,
  output logic [W_TONE-1:0]     treble_o,
  output logic [W_SPK-1:0]      spk_r_o,
  output logic [W_SPK-1:0]      spk_l_o,
  output logic                  wr_stb_o,
  output logic [FUNC_IDX_W-1:0] wr_idx_o
);
  logic scl_f, sda_f;
  logic                       wr_en;
  logic [FUNC_IDX_W-1:0]      wr_idx;
  logic [DATA_W-1:0]          wr_data;
  logic [NUM_FUNC*DATA_W-1:0] regs_flat;

  i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) scl_cond_i (
    .clk(clk), .rst(rst), .din(scl_i), .dout(scl_f)
  );
  i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) sda_cond_i (
    .clk(clk), .rst(rst), .din(sda_i), .dout(sda_f)
  );

  i2c_rx_fsm #(.DEV_ADDR(DEV_ADDR)) fsm_i (
    .clk(clk), .rst(rst), .scl(scl_f), .sda(sda_f), .sda_oe(sda_oe_o),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  audio_reg_bank bank_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .regs_flat(regs_flat), .stb(wr_stb_o), .stb_idx(wr_idx_o)
  );

  assign src_sel_o = regs_flat[0*DATA_W +: W_SEL];
  assign in_gain_o = regs_flat[1*DATA_W +: W_GAIN];
  assign volume_o  = regs_flat[2*DATA_W +: W_VOL];
  assign bass_o    = regs_flat[3*DATA_W +: W_TONE];
  assign treble_o  = regs_flat[5*DATA_W +: W_TONE];
  assign spk_r_o   = regs_flat[6*DATA_W +: W_SPK];
  assign spk_l_o   = regs_flat[7*DATA_W +: W_SPK];
endmodule

// File: rtl/audio_ctl_i2c_slave_chk.sv
module audio_ctl_i2c_slave_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_f,
  input logic       sda_oe_o,
  input logic       wr_stb_o,
  input logic [2:0] wr_idx_o,
  input logic [5:0] volume_o,
  input logic [6:0] spk_l_o,
  input logic [33:0] all_slots
);
  // R4: acknowledge drive toggles only while filtered SCL is low
  a_r4_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe_o) |-> !scl_f);

  // R9: strobe is a single-cycle pulse
  a_r9_stb_single: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |=> !wr_stb_o);

  // R12: no slot moves without a strobe
  a_r12_all_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_stb_o |-> $stable(all_slots));

  // R12: volume moves only on a strobe for slot 2
  a_r12_vol_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_stb_o || wr_idx_o != 3'd2) |-> $stable(volume_o));

  // R12: left speaker moves only on a strobe for slot 7
  a_r12_spkl_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_stb_o || wr_idx_o != 3'd7) |-> $stable(spk_l_o));
endmodule

bind audio_ctl_i2c_slave audio_ctl_i2c_slave_chk chk_i (
  .clk(clk), .rst(rst), .scl_f(scl_f), .sda_oe_o(sda_oe_o),
  .wr_stb_o(wr_stb_o), .wr_idx_o(wr_idx_o), .volume_o(volume_o),
  .spk_l_o(spk_l_o),
  .all_slots({src_sel_o, in_gain_o, volume_o, bass_o, treble_o, spk_r_o, spk_l_o})
);

// File: tb/audio_ctl_i2c_slave_tb_top.sv
module audio_ctl_i2c_slave_tb_top;
  localparam int Q = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic       sda_oe_o, wr_stb_o;
  logic [1:0] src_sel_o;
  logic [3:0] in_gain_o, bass_o, treble_o;
  logic [5:0] volume_o;
  logic [6:0] spk_r_o, spk_l_o;
  logic [2:0] wr_idx_o;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe_o;

  audio_ctl_i2c_slave dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe_o),
    .src_sel_o(src_sel_o), .in_gain_o(in_gain_o), .volume_o(volume_o),
    .bass_o(bass_o), .treble_o(treble_o), .spk_r_o(spk_r_o), .spk_l_o(spk_l_o),
    .wr_stb_o(wr_stb_o), .wr_idx_o(wr_idx_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int exp_r [8];
  logic [7:0] pay [16];
  int stb_log [64];
  int stb_cnt = 0;
  int exp_log [64];
  int exp_cnt = 0;
  int long_stb = 0;
  logic stb_prev = 1'b0;

  always @(negedge clk) begin
    if (wr_stb_o) begin
      if (stb_cnt < 64) stb_log[stb_cnt] = int'(wr_idx_o);
      stb_cnt++;
      if (stb_prev) long_stb++;
    end
    stb_prev = wr_stb_o;
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mask_of(input int i);
    case (i)
      0: return 3;
      1, 3, 5: return 15;
      2: return 63;
      6, 7: return 127;
      default: return 0;
    endcase
  endfunction

  function automatic int out_of(input int i);
    case (i)
      0: return int'(src_sel_o);
      1: return int'(in_gain_o);
      2: return int'(volume_o);
      3: return int'(bass_o);
      5: return int'(treble_o);
      6: return int'(spk_r_o);
      7: return int'(spk_l_o);
      default: return 0;
    endcase
  endfunction

  task automatic check_regs(input string req);
    for (int i = 0; i < 8; i++)
      if (i != 4) check($sformatf("%s slot%0d", req, i), out_of(i), exp_r[i]);
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q);
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b1; hold(Q);
    sda_m = 1'b1; hold(Q);
  endtask

  task automatic bus_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold(Q);
      scl_m = 1'b1; hold(2 * Q);
      scl_m = 1'b0; hold(Q);
    end
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q);
    acked = ~sda_line;
    hold(Q);
    acked = acked & ~sda_line;
    scl_m = 1'b0; hold(Q);
  endtask

  // model-driven write transfer: address, subaddress, n data bytes, STOP
  task automatic send_write(input string req, input logic [7:0] sub, input int n);
    bit ak;
    int idx;
    stb_cnt = 0; exp_cnt = 0;
    bus_start();
    bus_byte(8'h88, ak); check({req, " R3 addr ack"}, int'(ak), 1);
    bus_byte(sub, ak);   check({req, " R4 sub ack"}, int'(ak), 1);
    idx = int'(sub[3:0]);
    for (int k = 0; k < n; k++) begin
      bus_byte(pay[k], ak);
      check({req, " R4/R8 data ack"}, int'(ak), 1);
      if (idx < 8) begin
        exp_r[idx] = int'(pay[k]) & mask_of(idx);
        exp_log[exp_cnt] = idx;
        exp_cnt++;
      end
      if (sub[4]) idx = (idx + 1) % 16;
    end
    bus_stop();
    hold(4 * Q);
    check_regs(req);
    check({req, " R9 strobe count"}, stb_cnt, exp_cnt);
    for (int k = 0; k < exp_cnt && k < stb_cnt; k++)
      check({req, " R9 strobe index"}, stb_log[k], exp_log[k]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bit ak;
    exp_r[0] = 2; exp_r[1] = 14; exp_r[2] = 63; exp_r[3] = 7;
    exp_r[4] = 0; exp_r[5] = 14; exp_r[6] = 127; exp_r[7] = 127;
    hold(10);
    rst = 1'b0;
    hold(10);
    // R1 reset values
    check_regs("R1");
    check("R1 sda drive", int'(sda_oe_o), 0);
    check("R1 strobe", int'(wr_stb_o), 0);

    // R2 wrong address, read address, bytes without START
    stb_cnt = 0;
    bus_start();
    bus_byte(8'h8A, ak); check("R2 wrong addr nack", int'(ak), 0);
    bus_byte(8'h02, ak); check("R2 ignored sub", int'(ak), 0);
    bus_byte(8'h00, ak); check("R2 ignored data", int'(ak), 0);
    bus_stop();
    bus_start();
    bus_byte(8'h89, ak); check("R2 read addr nack", int'(ak), 0);
    bus_stop();
    bus_byte(8'h88, ak); check("R2 no start nack", int'(ak), 0);
    bus_byte(8'h02, ak);
    bus_byte(8'h00, ak);
    hold(4 * Q);
    check_regs("R2");
    check("R2 no strobe", stb_cnt, 0);

    // R5 R6 R8 R10: same-slot mode over all 16 indices, junk in bits 7:5
    for (int i = 0; i < 16; i++) begin
      pay[0] = 8'((i * 29 + 3));
      pay[1] = 8'((i * 53 + 200));
      send_write("R6 R5 R8 R10 same-slot", {3'(i), 1'b0, 4'(i)}, 2);
    end

    // R7 stepping mode from each function slot
    for (int s = 0; s < 8; s++) begin
      for (int k = 0; k < 10; k++) pay[k] = 8'((s * 37 + k * 11 + 5));
      send_write("R7 step", {3'b010, 1'b1, 4'(s)}, 10);
    end

    // R7 wrap 15 -> 0, R8 discard of 14 and 15
    for (int k = 0; k < 4; k++) pay[k] = 8'((k * 71 + 9));
    send_write("R7 R8 wrap", 8'h1E, 4);

    // R10 upper bits dropped on full-width bytes
    pay[0] = 8'hFF;
    send_write("R10 mask gain", 8'h01, 1);
    pay[0] = 8'hC1;
    send_write("R10 mask sel", 8'h00, 1);

    // R11 repeated START keeps contents and re-matches the address
    stb_cnt = 0;
    bus_start();
    bus_byte(8'h88, ak);
    bus_byte(8'h12, ak);
    bus_byte(8'h05, ak);
    exp_r[2] = 5;
    bus_start();
    bus_byte(8'h88, ak); check("R11 addr after restart", int'(ak), 1);
    bus_byte(8'h07, ak);
    bus_byte(8'h33, ak);
    exp_r[7] = 8'h33;
    bus_start();
    bus_byte(8'h90, ak); check("R11 wrong addr after restart", int'(ak), 0);
    bus_byte(8'h44, ak);
    bus_stop();
    hold(4 * Q);
    check_regs("R11");
    check("R11 strobe count", stb_cnt, 2);
    check("R9 no stretched strobe", long_stb, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule